// File: doc/BRIEF.md
# Shared Status-Channel Interrupt Encoder

This block builds the six-bit command/indicate field that one slave places in channel 1 of a multi-drop, IOM-2-style serial frame. It combines an 8-bit status word, an 8-bit enable mask and a 3-bit output mode. The field is captured once per frame at the frame-sync pulse. The block then shifts the field out in its slot on an open-drain style upstream line. A logic 0 is actively driven. A logic 1 is left to the bus pull-up, with the drive-enable low.

Three output modes exist. In the release mode the slave claims no field bit. In the single-request mode the slave pulls one chosen field bit low whenever any enabled status bit is set. In the direct mode the upper six status bits appear on the field, and disabled positions are held low.

The slot sequencer is a four-state machine:
- HUNT: the state after reset, before any sync has been seen.
- PRE: the frame is running and the slot has not yet arrived.
- SLOT: the six field bits are going out.
- POST: the slot is over and the rest of the frame runs out.

Its transitions are:
- HUNT→PRE on sync.
- PRE→SLOT when the slot's first half-bit is reached.
- SLOT→POST after the slot's last half-bit.
- POST→PRE at frame wrap.
- Any state→PRE on sync, which re-aligns the frame.

Top module: `ci_field_encoder`

## Requirements
- R1: With mode code 0, all six field bits are 1, and no bit is driven, whatever the status and mask values.
- R2: Mode codes 1 to 6 select field bit 0 to field bit 5, respectively. The selected bit is 0 while any status bit whose mask bit is 1 is also 1. Every other field bit is 1.
- R3: In modes 1 to 6, if no enabled status bit is set, all six field bits are 1. A status bit whose mask bit is 0 causes no request.
- R4: With mode code 7, field bit i equals status bit i+2 (field bits 5..0 carry status bits 7..2) wherever mask bit i+2 is 1.
- R5: With mode code 7, field bit i is 0 wherever mask bit i+2 is 0, independent of status.
- R6: The field is captured at the clock edge that samples frame sync high. A change to status, mask or mode later in the frame shows only in the next frame.
- R7: The frame has 96 bits and each bit lasts two clocks. The frame sync sampled high marks bit 0. Field bits 5 down to 0 go out on frame bits 56 to 61, most significant first.
- R8: Outside frame bits 56 to 61, the data output is 1 and the drive-enable is 0. This includes frame bits 62 and 63.
- R9: The drive-enable is 1 only while the data output is 0. A field bit of 1 is never driven.
- R10: After reset and until the first frame sync, the data output is 1 and the drive-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, twice the bit rate, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, one clock high at the start of frame bit 0 |
| status | input | 8 | Status word |
| irq_mask | input | 8 | Enable mask; 1 enables the matching status bit |
| mode_code | input | 3 | Output mode: 0 release, 1–6 single request, 7 direct |
| du_data | output | 1 | Upstream serial data bit |
| du_oe | output | 1 | Drive-enable for the upstream line |

## Verification
The release mode is tried with every status and mask bit set and again with everything clear. Identical all-ones results show that the mask is ignored there.

Single-request modes are tried on the lowest, a middle and the highest field bit. Each has a request present, which tells the bit selection apart. One case has set status bits that are all masked, which separates the mask gate from the status alone.

Direct mode is tried with a fully open mask and then with a partial mask over set status bits. This tells the straight mapping apart from the forced-low positions.

One frame changes every input halfway through. It shows whether the old field survives to the end of that frame and the new field appears in the next.

// File: rtl/cif_pkg.sv
package cif_pkg;
    localparam int STAT_W      = 8;
    localparam int FIELD_W     = 6;
    localparam int CODE_W      = 3;
    localparam int FRAME_BITS  = 96;
    localparam int SLOT_BIT    = 56;
    localparam int CLK_PER_BIT = 2;

    localparam logic [CODE_W-1:0] CODE_RELEASE = '0;
    localparam logic [CODE_W-1:0] CODE_DIRECT  = '1;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PRE,
        ST_SLOT,
        ST_POST
    } slot_state_e;
endpackage

// File: rtl/cif_field_enc.sv
module cif_field_enc
    import cif_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int FW = FIELD_W,
    parameter int CW = CODE_W
) (
    input  logic [SW-1:0] status,
    input  logic [SW-1:0] irq_mask,
    input  logic [CW-1:0] mode_code,
    output logic [FW-1:0] field
);
    localparam int OFS = SW - FW;

    logic          req_any;
    logic [FW-1:0] direct_val;
    logic [FW-1:0] single_val;

    assign req_any = |(status & irq_mask);

    for (genvar i = 0; i < FW; i++) begin : g_bit
        assign direct_val[i] = irq_mask[i+OFS] & status[i+OFS];
        assign single_val[i] = !(req_any && (mode_code == CW'(i + 1)));
    end

    always_comb begin
        unique case (mode_code)
            CODE_RELEASE: field = '1;
            CODE_DIRECT:  field = direct_val;
            default:      field = single_val;
        endcase
    end

    always_comb begin
        if (mode_code == CODE_RELEASE)
            AST_RELEASE_ALL_ONES: assert (field == '1);                    // R1
        if (mode_code != CODE_RELEASE && mode_code != CODE_DIRECT)
            AST_SINGLE_AT_MOST_ONE: assert ($countones(~field) <= 1);      // R2
        if (mode_code != CODE_DIRECT && !req_any)
            AST_NO_REQ_RELEASE: assert (field == '1);                      // R3
        if (mode_code == CODE_DIRECT)
            AST_MASKED_LOW: assert ((field & ~irq_mask[SW-1:OFS]) == '0);  // R5
    end
endmodule

// File: rtl/cif_slot_timer.sv
module cif_slot_timer
    import cif_pkg::*;
#(
    parameter int NBITS = FRAME_BITS,
    parameter int FIRST = SLOT_BIT,
    parameter int FW    = FIELD_W,
    parameter int CPB   = CLK_PER_BIT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fsync,
    output slot_state_e           state,
    output logic [$clog2(FW)-1:0] bit_idx
);
    localparam int HALVES  = NBITS * CPB;
    localparam int PW      = $clog2(HALVES);
    localparam int IW      = $clog2(FW);
    localparam int SLOT_LO = FIRST * CPB;
    localparam int SLOT_HI = SLOT_LO + FW * CPB - 1;

    logic [PW-1:0] pos, pos_nxt;
    slot_state_e   state_nxt;
    logic [PW-1:0] slot_off;

    always_comb begin
        if (fsync)                         pos_nxt = '0;
        else if (state == ST_HUNT)         pos_nxt = '0;
        else if (pos == PW'(HALVES - 1))   pos_nxt = '0;
        else                               pos_nxt = pos + 1'b1;
    end

    always_comb begin
        state_nxt = state;
        if (fsync) begin
            state_nxt = ST_PRE;
        end else begin
            unique case (state)
                ST_HUNT: state_nxt = ST_HUNT;
                ST_PRE:  if (pos_nxt == PW'(SLOT_LO))     state_nxt = ST_SLOT;
                ST_SLOT: if (pos_nxt == PW'(SLOT_HI + 1)) state_nxt = ST_POST;
                ST_POST: if (pos_nxt == '0)               state_nxt = ST_PRE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            pos   <= '0;
        end else begin
            state <= state_nxt;
            pos   <= pos_nxt;
        end
    end

    assign slot_off = pos - PW'(SLOT_LO);
    assign bit_idx  = IW'(slot_off / PW'(CPB));

    AST_HUNT_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && !fsync) |=> state == ST_HUNT);             // R10
    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SLOT |-> bit_idx < IW'(FW));                         // R7
endmodule

// File: rtl/ci_field_encoder.sv
module ci_field_encoder
    import cif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] irq_mask,
    input  logic [CODE_W-1:0] mode_code,
    output logic              du_data,
    output logic              du_oe
);
    localparam int IW = $clog2(FIELD_W);

    logic [FIELD_W-1:0] enc_field;
    logic [FIELD_W-1:0] field_q;
    slot_state_e        state;
    logic [IW-1:0]      bit_idx;
    logic               cur_bit;

    cif_field_enc #(.SW(STAT_W), .FW(FIELD_W), .CW(CODE_W)) u_enc (
        .status    (status),
        .irq_mask  (irq_mask),
        .mode_code (mode_code),
        .field     (enc_field)
    );

    cif_slot_timer #(.NBITS(FRAME_BITS), .FIRST(SLOT_BIT), .FW(FIELD_W), .CPB(CLK_PER_BIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .state   (state),
        .bit_idx (bit_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     field_q <= '1;
        else if (fsync) field_q <= enc_field;
    end

    assign cur_bit = field_q[IW'(FIELD_W - 1) - bit_idx];

    always_comb begin
        unique case (state)
            ST_SLOT: begin
                du_data = cur_bit;
                du_oe   = !cur_bit;
            end
            default: begin
                du_data = 1'b1;
                du_oe   = 1'b0;
            end
        endcase
    end

    AST_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> $stable(field_q));                                    // R6
    AST_IDLE_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_SLOT |-> (du_data && !du_oe));                       // R8
    AST_DRIVE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        du_oe |-> !du_data);                                             // R9
endmodule

// File: tb/sim_ci_field_encoder.sv
module sim_ci_field_encoder;
    localparam int PERIOD = 10;
    localparam int HALVES = 192;
    localparam int SLOT_LO = 112;
    localparam int SLOT_END = 123;

    typedef struct {
        logic [5:0] field;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] status = '0;
    logic [7:0] irq_mask = '0;
    logic [2:0] mode_code = '0;
    logic       du_data, du_oe;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    ci_field_encoder u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .status(status),
        .irq_mask(irq_mask), .mode_code(mode_code),
        .du_data(du_data), .du_oe(du_oe)
    );

    function automatic logic [5:0] expect_field(logic [7:0] s, logic [7:0] m, logic [2:0] c);
        logic [5:0] r;
        r = 6'h3F;
        if (c == 3'd7) begin
            for (int i = 0; i < 6; i++) r[i] = m[i+2] & s[i+2];
        end else if (c != 3'd0) begin
            if ((s & m) != 8'h00) r[c-1] = 1'b0;
        end
        return r;
    endfunction

    task automatic run_frame(input logic [7:0] s, input logic [7:0] m, input logic [2:0] c,
                             input string tag, input bit mid,
                             input logic [7:0] s2, input logic [7:0] m2, input logic [2:0] c2);
        exp_t e;
        @(negedge clk);
        status = s; irq_mask = m; mode_code = c; fsync = 1'b1;
        e.field = expect_field(s, m, c);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        fsync = 1'b0;
        if (mid) begin
            repeat (60) @(negedge clk);
            status = s2; irq_mask = m2; mode_code = c2;
            repeat (130) @(negedge clk);
        end else begin
            repeat (190) @(negedge clk);
        end
    endtask

    int         mpos = 0;
    bit         synced = 0;
    logic [5:0] got;
    bit         half_bad = 0;
    bit         out_bad = 0;
    bit         oe_bad = 0;

    always @(posedge clk) begin
        if (!rst_n) synced = 0;
        else if (fsync) begin mpos = 0; synced = 1; end
        else if (synced) mpos = (mpos == HALVES-1) ? 0 : mpos + 1;
    end

    always @(negedge clk) begin
        if (rst_n && synced) begin
            if (mpos >= SLOT_LO && mpos <= SLOT_END) begin
                int idx;
                idx = 5 - (mpos - SLOT_LO) / 2;
                if (mpos % 2 == 0) got[idx] = du_data;
                else if (got[idx] !== du_data) half_bad = 1;
                if (du_oe !== !du_data) oe_bad = 1;
            end else if (du_data !== 1'b1 || du_oe !== 1'b0) begin
                out_bad = 1;
            end
            if (mpos == SLOT_END) begin
                exp_t e;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R7 field with no expectation: got %b expected none", got);
                end else begin
                    e = q.pop_front();
                    if (got !== e.field) begin
                        errors++;
                        $display("FAIL %s field got %b expected %b", e.tag, got, e.field);
                    end
                end
                checks++;
                if (half_bad) begin
                    errors++;
                    $display("FAIL R7 bit not held for two clocks: got 1 expected 0");
                end
                checks++;
                if (oe_bad) begin
                    errors++;
                    $display("FAIL R9 drive-enable not inverse of data in slot: got 1 expected 0");
                end
                half_bad = 0; oe_bad = 0;
            end
            if (mpos == HALVES-1) begin
                checks++;
                if (out_bad) begin
                    errors++;
                    $display("FAIL R8 line not idle outside slot: got 1 expected 0");
                end
                out_bad = 0;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        checks++;
        if (du_data !== 1'b1 || du_oe !== 1'b0) begin
            errors++;
            $display("FAIL R10 pre-sync output got %b%b expected 10", du_data, du_oe);
        end

        run_frame(8'hFF, 8'hFF, 3'd0, "R1", 0, 0, 0, 0);
        run_frame(8'h00, 8'h00, 3'd0, "R1", 0, 0, 0, 0);
        run_frame(8'h04, 8'h0C, 3'd1, "R2", 0, 0, 0, 0);
        run_frame(8'h80, 8'hFF, 3'd3, "R2", 0, 0, 0, 0);
        run_frame(8'h01, 8'h01, 3'd6, "R2", 0, 0, 0, 0);
        run_frame(8'hF0, 8'h0F, 3'd4, "R3", 0, 0, 0, 0);
        run_frame(8'h00, 8'hFF, 3'd2, "R3", 0, 0, 0, 0);
        run_frame(8'hB4, 8'hFF, 3'd7, "R4", 0, 0, 0, 0);
        run_frame(8'hFC, 8'h5C, 3'd7, "R5", 0, 0, 0, 0);
        run_frame(8'h00, 8'hFF, 3'd7, "R6", 1, 8'hFF, 8'hFF, 3'd5);
        run_frame(8'hFF, 8'hFF, 3'd5, "R6", 0, 0, 0, 0);
        @(negedge clk);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R7 frames not observed: got %0d pending expected 0", q.size());
        end
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule